// File: doc/BRIEF.md
# Multi-Core Interrupt Routing Unit

This block gathers two groups of peripheral interrupt sources, each up to 64 bits wide, into two registered summary vectors and steers them to a set of processor cores. Every core owns two interrupt lines. Line 0 of a core is driven from the first summary group through its own enable register. Line 1 is driven from the second group through a second enable register. A line asserts whenever any summary bit meets a set enable bit. Next to each line, a priority encoder reports the index of the highest pending enabled bit, which dispatch software serves first.

Sources come in two classes. Ordinary sources follow their input level one clock later. Timer-class sources, chosen per bit by a parameter, catch a rising input edge and hold it until software writes a one to that summary bit. Software reaches the block through a single-cycle register port. Each enable register can be replaced outright or changed bit by bit through set-mask and clear-mask operations, so one core's enable bits never need a read-modify-write.

Top module: `irq_router`

## Requirements
- R1: After reset every enable register and both summary vectors read 0, every `irq_o` bit is 0 and every `prio_vld_o` bit is 0.
- R2: Address bit AW-1 = 0 selects enable register `addr[AW-2:0]`. Register 2c belongs to line 2c (core c, line 0) and gates summary group 0. Register 2c+1 belongs to line 2c+1 (core c, line 1) and gates summary group 1. Address bit AW-1 = 1 selects summary group `addr[0]`.
- R3: A write with op 0 to an enable register replaces all of its bits. `bus_rdata_o` always shows, with no delay, the current value of the register that `bus_addr_i` selects.
- R4: A write with op 1 to an enable register sets exactly the bits that are 1 in `bus_wdata_i`. Every other bit, and every other register, keeps its value.
- R5: A write with op 2 to an enable register clears exactly the bits that are 1 in `bus_wdata_i`. Every other bit keeps its value. Op 3 changes nothing.
- R6: A level-class summary bit equals its source input as sampled at the previous clock edge. Writes to the summary do not affect it.
- R7: A timer-class summary bit sets on a rising edge of its source and then stays set, even after the source falls. A write of any op to its summary group clears it only where `bus_wdata_i` holds a 1. Writing a 0 has no effect.
- R8: If a timer-class edge and a clearing write for the same bit land in the same cycle, the bit ends up set.
- R9: `irq_o[l]` is 1 exactly when the AND of line l's enable register and its summary group is nonzero. Its delay from the source is one clock.
- R10: `prio_idx_o[l*6 +: 6]` is the index of the highest set bit of line l's AND. `prio_vld_o[l]` is 0 when that AND is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src0_i | input | SRC_W | Source inputs of summary group 0 |
| src1_i | input | SRC_W | Source inputs of summary group 1 |
| bus_we_i | input | 1 | Write strobe for this cycle |
| bus_op_i | input | 2 | 0 replace, 1 set mask, 2 clear mask, 3 none |
| bus_addr_i | input | AW | Register select (see R2) |
| bus_wdata_i | input | SRC_W | Write data or mask |
| bus_rdata_o | output | SRC_W | Value of the addressed register |
| irq_o | output | 2*NCORES | Interrupt line per core and line |
| prio_idx_o | output | 2*NCORES*6 | Highest pending enabled index per line |
| prio_vld_o | output | 2*NCORES | Pending flag per line |

## Verification
The bench aims at cases where masked enable updates could disturb their neighbours. A design that wrote the mask through as data would wipe unrelated bits on a set or clear. One that decoded the index wrongly would enable the wrong core. For timer-class sources, the bench drops the input right after an edge. It also writes zero masks, and it fires an edge in the same cycle as a clear of that bit. A level-following or clear-wins design would then drop an event or keep a stale one. Group 1 sources are kept apart from group 0 and several bits pend at once. This exposes a swapped line feed, and a priority encoder that picks the lowest bit rather than the highest.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    typedef enum logic [1:0] {
        OP_REPLACE = 2'd0,
        OP_SETMASK = 2'd1,
        OP_CLRMASK = 2'd2,
        OP_IDLE    = 2'd3
    } bus_op_e;
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
    parameter int          W     = 64,
    parameter logic [W-1:0] TMASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] sum_o
);
    typedef struct packed {
        logic [W-1:0] sum;
        logic [W-1:0] prev;
    } lat_t;

    lat_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = src_i;
        for (int b = 0; b < W; b++) begin
            if (TMASK[b]) begin
                // edge capture; a fresh edge overrides a same-cycle clear
                st_d.sum[b] = (st_q.sum[b] & ~clr_i[b]) | (src_i[b] & ~st_q.prev[b]);
            end else begin
                st_d.sum[b] = src_i[b];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum_o = st_q.sum;
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
    import irq_route_pkg::*;
#(
    parameter int W    = 64,
    parameter int NREG = 8,
    localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_i,
    input  logic [1:0]              op_i,
    input  logic [IW-1:0]           idx_i,
    input  logic [W-1:0]            wdata_i,
    output logic [NREG-1:0][W-1:0]  en_o
);
    typedef struct packed {
        logic [NREG-1:0][W-1:0] en;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        for (int r = 0; r < NREG; r++) begin
            if (we_i && idx_i == IW'(r)) begin
                case (bus_op_e'(op_i))
                    OP_REPLACE: bk_d.en[r] = wdata_i;
                    OP_SETMASK: bk_d.en[r] = bk_q.en[r] | wdata_i;
                    OP_CLRMASK: bk_d.en[r] = bk_q.en[r] & ~wdata_i;
                    default:    bk_d.en[r] = bk_q.en[r];
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign en_o = bk_q.en;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int W   = 64,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic          vld_o
);
    always_comb begin
        idx_o = '0;
        vld_o = 1'b0;
        for (int b = 0; b < W; b++) begin
            if (vec_i[b]) begin
                idx_o = IW'(b);
                vld_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_route_pkg::*;
#(
    parameter int              NCORES      = 4,
    parameter int              SRC_W       = 64,
    parameter logic [SRC_W-1:0] TIMER_MASK0 = 64'h0000_00F0_0000_0F00,
    parameter logic [SRC_W-1:0] TIMER_MASK1 = 64'h0000_0000_0000_0003,
    localparam int NLINE = 2 * NCORES,
    localparam int EIW   = $clog2(NLINE),
    localparam int AW    = EIW + 1,
    localparam int PIW   = $clog2(SRC_W)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SRC_W-1:0]       src0_i,
    input  logic [SRC_W-1:0]       src1_i,
    input  logic                   bus_we_i,
    input  logic [1:0]             bus_op_i,
    input  logic [AW-1:0]          bus_addr_i,
    input  logic [SRC_W-1:0]       bus_wdata_i,
    output logic [SRC_W-1:0]       bus_rdata_o,
    output logic [NLINE-1:0]       irq_o,
    output logic [NLINE*PIW-1:0]   prio_idx_o,
    output logic [NLINE-1:0]       prio_vld_o
);
    logic                        sel_sum;
    logic [EIW-1:0]              eidx;
    logic                        en_we;
    logic [SRC_W-1:0]            clr0, clr1;
    logic [SRC_W-1:0]            sum0, sum1;
    logic [NLINE-1:0][SRC_W-1:0] en_all;

    assign sel_sum = bus_addr_i[AW-1];
    assign eidx    = bus_addr_i[EIW-1:0];
    assign en_we   = bus_we_i && !sel_sum;
    assign clr0    = (bus_we_i && sel_sum && !bus_addr_i[0]) ? bus_wdata_i : '0;
    assign clr1    = (bus_we_i && sel_sum &&  bus_addr_i[0]) ? bus_wdata_i : '0;

    irq_src_latch #(.W(SRC_W), .TMASK(TIMER_MASK0)) u_grp0 (
        .clk(clk), .rst_n(rst_n), .src_i(src0_i), .clr_i(clr0), .sum_o(sum0)
    );

    irq_src_latch #(.W(SRC_W), .TMASK(TIMER_MASK1)) u_grp1 (
        .clk(clk), .rst_n(rst_n), .src_i(src1_i), .clr_i(clr1), .sum_o(sum1)
    );

    irq_enable_bank #(.W(SRC_W), .NREG(NLINE)) u_bank (
        .clk(clk), .rst_n(rst_n), .we_i(en_we), .op_i(bus_op_i),
        .idx_i(eidx), .wdata_i(bus_wdata_i), .en_o(en_all)
    );

    for (genvar l = 0; l < NLINE; l++) begin : g_line
        logic [SRC_W-1:0] pend;
        assign pend     = ((l % 2) == 0 ? sum0 : sum1) & en_all[l];
        assign irq_o[l] = |pend;
        irq_prio_enc #(.W(SRC_W)) u_enc (
            .vec_i(pend),
            .idx_o(prio_idx_o[l*PIW +: PIW]),
            .vld_o(prio_vld_o[l])
        );
    end

    always_comb begin
        bus_rdata_o = '0;
        if (sel_sum) begin
            bus_rdata_o = bus_addr_i[0] ? sum1 : sum0;
        end else begin
            for (int r = 0; r < NLINE; r++) begin
                if (eidx == EIW'(r)) bus_rdata_o = en_all[r];
            end
        end
    end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int               NCORES      = 4,
    parameter int               SRC_W       = 64,
    parameter logic [SRC_W-1:0] TIMER_MASK0 = '0,
    localparam int NLINE = 2 * NCORES,
    localparam int EIW   = $clog2(NLINE),
    localparam int AW    = EIW + 1
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [SRC_W-1:0]            src0_i,
    input logic                        bus_we_i,
    input logic [1:0]                  bus_op_i,
    input logic [AW-1:0]               bus_addr_i,
    input logic [SRC_W-1:0]            bus_wdata_i,
    input logic [NLINE-1:0][SRC_W-1:0] en_all,
    input logic [SRC_W-1:0]            sum0,
    input logic [NLINE-1:0]            irq_o,
    input logic [NLINE-1:0]            prio_vld_o
);
    logic [SRC_W-1:0] clr_m0;
    logic [SRC_W-1:0] hold0;
    assign clr_m0 = (bus_we_i && bus_addr_i[AW-1] && !bus_addr_i[0]) ? bus_wdata_i : '0;
    assign hold0  = sum0 & TIMER_MASK0 & ~clr_m0;

    // R4
    setmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && !bus_addr_i[AW-1] && bus_op_i == 2'd1)
        |=> ((en_all[$past(bus_addr_i[EIW-1:0])] & $past(bus_wdata_i)) == $past(bus_wdata_i)));

    // R5
    clrmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && !bus_addr_i[AW-1] && bus_op_i == 2'd2)
        |=> ((en_all[$past(bus_addr_i[EIW-1:0])] & $past(bus_wdata_i)) == '0));

    // R6
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((sum0 & ~TIMER_MASK0) == ($past(src0_i) & ~TIMER_MASK0)));

    // R7
    timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((sum0 & $past(hold0)) == $past(hold0)));

    // R10
    vld_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prio_vld_o == irq_o);
endmodule

bind irq_router irq_router_chk #(
    .NCORES(NCORES), .SRC_W(SRC_W), .TIMER_MASK0(TIMER_MASK0)
) u_chk (
    .clk(clk), .rst_n(rst_n), .src0_i(src0_i), .bus_we_i(bus_we_i),
    .bus_op_i(bus_op_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .en_all(en_all), .sum0(sum0), .irq_o(irq_o), .prio_vld_o(prio_vld_o)
);

// File: tb/irq_router_test.sv
module irq_router_test;
    localparam int NC = 4;
    localparam int NL = 2 * NC;
    localparam int W  = 64;
    localparam logic [W-1:0] TM0 = 64'h0000_00F0_0000_0F00;
    localparam logic [W-1:0] TM1 = 64'h0000_0000_0000_0003;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [W-1:0]    src0 = '0, src1 = '0;
    logic            we = 1'b0;
    logic [1:0]      op = 2'd3;
    logic [3:0]      addr = '0;
    logic [W-1:0]    wd = '0;
    logic [W-1:0]    rdata;
    logic [NL-1:0]   irq;
    logic [NL*6-1:0] pidx;
    logic [NL-1:0]   pvld;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [W-1:0] m_en [NL];
    logic [W-1:0] m_sum [2];
    logic [W-1:0] m_prev [2];

    always #2 clk = ~clk;

    irq_router uut (
        .clk(clk), .rst_n(rst_n), .src0_i(src0), .src1_i(src1),
        .bus_we_i(we), .bus_op_i(op), .bus_addr_i(addr), .bus_wdata_i(wd),
        .bus_rdata_o(rdata), .irq_o(irq), .prio_idx_o(pidx), .prio_vld_o(pvld)
    );

    function automatic int hi_bit(input logic [W-1:0] v);
        int r = 0;
        for (int b = 0; b < W; b++) if (v[b]) r = b;
        return r;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_edge();
        logic [W-1:0] s [2];
        logic [W-1:0] tm [2];
        s[0] = src0; s[1] = src1; tm[0] = TM0; tm[1] = TM1;
        for (int g = 0; g < 2; g++) begin
            logic [W-1:0] clr;
            clr = (we && addr[3] && addr[0] == g[0]) ? wd : '0;
            m_sum[g] = (tm[g] & ((m_sum[g] & ~clr) | (s[g] & ~m_prev[g]))) | (~tm[g] & s[g]);
            m_prev[g] = s[g];
        end
        if (we && !addr[3]) begin
            case (op)
                2'd0: m_en[addr[2:0]] = wd;
                2'd1: m_en[addr[2:0]] = m_en[addr[2:0]] | wd;
                2'd2: m_en[addr[2:0]] = m_en[addr[2:0]] & ~wd;
                default: ;
            endcase
        end
    endtask

    task automatic check_lines(input string req);
        logic [NL-1:0] ei;
        for (int l = 0; l < NL; l++) begin
            logic [W-1:0] p;
            p = m_sum[l % 2] & m_en[l];
            ei[l] = |p;
            chk({req, " idx"}, W'(pidx[l*6 +: 6]), p != 0 ? W'(hi_bit(p)) : W'(0));
        end
        chk({req, " irq"}, W'(irq), W'(ei));
        chk({req, " vld"}, W'(pvld), W'(ei));
    endtask

    task automatic step(input logic [W-1:0] s0, input logic [W-1:0] s1, input logic w,
                        input logic [1:0] o, input logic [3:0] a, input logic [W-1:0] d,
                        input string req);
        src0 = s0; src1 = s1; we = w; op = o; addr = a; wd = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        we = 1'b0; op = 2'd3;
        check_lines(req);
    endtask

    task automatic rd(input logic [3:0] a, input logic [W-1:0] exp, input string req);
        addr = a; #0.5;
        chk(req, rdata, exp);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NL; i++) m_en[i] = '0;
        for (int g = 0; g < 2; g++) begin m_sum[g] = '0; m_prev[g] = '0; end
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_lines("R1");
        for (int i = 0; i < 10; i++) rd(4'(i < NL ? i : (i - NL) + 8), '0, "R1 readback");

        // R4 set mask keeps others
        step('0, '0, 1, 2'd1, 4'd2, 64'hA5, "R4");
        rd(4'd2, 64'hA5, "R4 set");
        step('0, '0, 1, 2'd1, 4'd2, 64'h0F, "R4");
        rd(4'd2, 64'hAF, "R4 keep");
        rd(4'd3, 64'h0, "R4 other reg");
        // R5 clear mask, op 3 idle
        step('0, '0, 1, 2'd2, 4'd2, 64'h05, "R5");
        rd(4'd2, 64'hAA, "R5 clear");
        step('0, '0, 1, 2'd3, 4'd2, 64'hFF, "R5");
        rd(4'd2, 64'hAA, "R5 idle op");
        // R3 replace
        step('0, '0, 1, 2'd0, 4'd3, 64'h1234, "R3");
        rd(4'd3, 64'h1234, "R3 replace");

        // R6 level source on line 0
        step('0, '0, 1, 2'd0, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
        step(64'h1, '0, 0, 2'd3, 4'd0, '0, "R6 rise");
        chk("R9 line0", W'(irq[0]), 64'h1);
        step(64'h1, '0, 1, 2'd2, 4'd8, 64'h1, "R6 write ignored");
        rd(4'd8, 64'h1, "R6 summary held");
        step('0, '0, 0, 2'd3, 4'd0, '0, "R6 fall");
        chk("R6 line0 low", W'(irq[0]), 64'h0);

        // R7 timer bit 8 pulse latches
        step(64'h100, '0, 0, 2'd3, 4'd0, '0, "R7");
        step('0, '0, 0, 2'd3, 4'd0, '0, "R7 held");
        rd(4'd8, 64'h100, "R7 latched");
        chk("R10 idx8", W'(pidx[5:0]), 64'd8);
        step('0, '0, 1, 2'd0, 4'd8, 64'h0, "R7 zero write");
        rd(4'd8, 64'h100, "R7 zero no effect");
        step('0, '0, 1, 2'd0, 4'd8, 64'h100, "R7 clear");
        rd(4'd8, 64'h0, "R7 cleared");

        // R8 edge and clear same cycle
        step(64'h200, '0, 1, 2'd2, 4'd8, 64'h200, "R8");
        rd(4'd8, 64'h200, "R8 set wins");

        // R2 group 1 only reaches odd lines; R10 highest
        step('0, '0, 1, 2'd0, 4'd5, 64'hFFFF_FFFF_FFFF_FFFF, "R2");
        step('0, 64'h8000_0000_0000_0010, 0, 2'd3, 4'd0, '0, "R2 grp1");
        chk("R2 line5", W'(irq[5]), 64'h1);
        chk("R2 line4", W'(irq[4]), 64'h0);
        chk("R10 idx63", W'(pidx[5*6 +: 6]), 64'd63);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic [W-1:0] s0, s1, d;
            logic [3:0] a;
            s0 = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            s1 = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            d  = {$urandom, $urandom};
            a  = ($urandom % 3 == 0) ? {1'b1, 2'b00, 1'($urandom)} : {1'b0, 3'($urandom)};
            step(s0, s1, 1'($urandom), 2'($urandom), a, d, "R9 random");
            if (n % 8 == 0) rd(a, a[3] ? m_sum[a[0]] : m_en[a[2:0]], "R3 random read");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule